// File: doc/BRIEF.md
# Tile and Object Pixel Priority Mixer

This block sits at the end of a tile-based video pipeline and produces one palette lookup per pixel clock. For the current screen column it receives one playfield pixel (two plane bits and a two-bit palette select) and a set of object candidates. Each candidate brings the two 8-pixel plane rows of its current line, the column inside the object, a coverage flag, a mirror flag, a behind-playfield flag and a two-bit palette select.

The mixer extracts each object's pixel and treats pattern value zero as see-through. It then gives the pixel to the lowest-numbered object that is not see-through. That object keeps the position even when it sits behind an opaque playfield pixel, so a higher-numbered foreground object cannot show through there. Separate left-margin blanking applies to the playfield and to objects.

The winning colour becomes a 5-bit palette index and a palette memory address. Both are registered and appear one clock later, together with a valid strobe.

Top module: `pmx_mixer`

## Requirements
- R1: A playfield pixel's pattern value is {bg_plane1, bg_plane0} (plane 1 is the high bit). When it is shown, the index is {1'b0, bg_pal, pattern}, in the range 0 to 15.
- R2: Pattern value 0 is see-through for both the playfield and objects. When nothing visible remains, the output index is 0.
- R3: A shown object pixel gives the index {1'b1, obj_pal, pattern}, in the range 16 to 31.
- R4: Among the objects with obj_hit set and a nonzero pattern, the lowest-numbered one claims the position.
- R5: The claiming object is shown if its obj_behind is 0 or the playfield pattern is 0. Otherwise the playfield is shown. In both cases, higher-numbered objects stay excluded.
- R6: An object's pixel uses the bit pair of its rows at bit position 7 - obj_col when obj_flip is 0, and at bit position obj_col when obj_flip is 1 (bit 7 is the leftmost pixel).
- R7: When blank_bg is 1 and pix_x < 8, the playfield pattern is treated as 0.
- R8: When blank_obj is 1 and pix_x < 8, no object can be shown, and an opaque playfield pixel appears.
- R9: out_addr equals 14'h3F00 plus out_index.
- R10: out_valid and out_index follow in_valid and its inputs one clock later. After reset, out_valid is 0 and out_index is 0.
- R11: An object whose obj_hit is 0 has no effect, whatever its row data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inputs hold a pixel this cycle |
| pix_x | input | X_W | Screen column of the pixel |
| blank_bg | input | 1 | Hide the playfield in the left margin |
| blank_obj | input | 1 | Hide objects in the left margin |
| bg_plane0 | input | 1 | Playfield low pattern bit |
| bg_plane1 | input | 1 | Playfield high pattern bit |
| bg_pal | input | 2 | Playfield palette select |
| obj_hit | input | N_OBJ | Object covers this column |
| obj_row0 | input | N_OBJ*8 | Per-object plane 0 row, object i at [8i+7:8i] |
| obj_row1 | input | N_OBJ*8 | Per-object plane 1 row |
| obj_col | input | N_OBJ*3 | Column inside each object |
| obj_flip | input | N_OBJ | Mirror the object horizontally |
| obj_behind | input | N_OBJ | Object lies behind opaque playfield |
| obj_pal | input | N_OBJ*2 | Object palette select |
| out_valid | output | 1 | Registered pixel strobe |
| out_index | output | 5 | Registered palette index |
| out_addr | output | 14 | Palette memory address |

## Verification
The assertions take the inputs as given:
- they assume a two-state pixel presented on every in_valid cycle;
- they assume reset has been released before they fire.

They also assume the candidate rows are stable within the cycle they are sampled. The bench drives inputs on the falling edge, so each set is settled before the rising edge that captures it. The stimulus uses a four-object configuration and keeps pix_x in 0 to 15, so that both sides of the margin boundary appear often in the pseudo-random sweep. Directed cases set up ties between objects, behind-playfield clashes and mirror bits one at a time.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
   localparam int PMX_PAT_W = 2;
   localparam int PMX_PAL_W = 2;
   localparam int PMX_IDX_W = 1 + PMX_PAL_W + PMX_PAT_W;

   typedef struct packed {
      logic                 is_obj;
      logic [PMX_PAL_W-1:0] pal;
      logic [PMX_PAT_W-1:0] pat;
   } pmx_idx_t;
endpackage

// File: rtl/pmx_obj_pixel.sv
module pmx_obj_pixel #(
   parameter int ROW_W = 8,
   localparam int COL_W = $clog2(ROW_W)
) (
   input  logic             hit,
   input  logic [ROW_W-1:0] row0,
   input  logic [ROW_W-1:0] row1,
   input  logic [COL_W-1:0] col,
   input  logic             flip,
   output logic [1:0]       pat
);
   logic [COL_W-1:0] bitpos;

   always_comb begin
      bitpos = flip ? col : COL_W'(ROW_W - 1) - col;
      pat    = hit ? {row1[bitpos], row0[bitpos]} : 2'b00;
   end
endmodule

// File: rtl/pmx_claim.sv
module pmx_claim #(
   parameter int N = 64
) (
   input  logic [N-1:0] opaque,
   output logic [N-1:0] first,
   output logic         any
);
   logic [N:0] seen;

   assign seen[0] = 1'b0;

   generate
      for (genvar i = 0; i < N; i++) begin : g_chain
         assign first[i]  = opaque[i] & ~seen[i];
         assign seen[i+1] = seen[i] | opaque[i];
      end
   endgenerate

   assign any = seen[N];
endmodule

// File: rtl/pmx_mixer.sv
module pmx_mixer #(
   parameter int          N_OBJ    = 64,
   parameter int          X_W      = 8,
   parameter int          CLIP_W   = 8,
   parameter int          ADDR_W   = 14,
   parameter logic [13:0] PAL_BASE = 14'h3F00,
   localparam int ROW_W = 8,
   localparam int COL_W = $clog2(ROW_W),
   localparam int IDX_W = pmx_pkg::PMX_IDX_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [X_W-1:0]         pix_x,
   input  logic                   blank_bg,
   input  logic                   blank_obj,
   input  logic                   bg_plane0,
   input  logic                   bg_plane1,
   input  logic [1:0]             bg_pal,
   input  logic [N_OBJ-1:0]       obj_hit,
   input  logic [N_OBJ*ROW_W-1:0] obj_row0,
   input  logic [N_OBJ*ROW_W-1:0] obj_row1,
   input  logic [N_OBJ*COL_W-1:0] obj_col,
   input  logic [N_OBJ-1:0]       obj_flip,
   input  logic [N_OBJ-1:0]       obj_behind,
   input  logic [N_OBJ*2-1:0]     obj_pal,
   output logic                   out_valid,
   output logic [IDX_W-1:0]       out_index,
   output logic [ADDR_W-1:0]      out_addr
);
   import pmx_pkg::*;

   generate
      if (N_OBJ < 1) begin : g_bad_n
         $error("pmx_mixer: N_OBJ must be at least 1");
      end
      if (CLIP_W >= (1 << X_W)) begin : g_bad_clip
         $error("pmx_mixer: CLIP_W must fit below the column range");
      end
      if (ADDR_W < IDX_W) begin : g_bad_addr
         $error("pmx_mixer: ADDR_W too narrow for the palette index");
      end
      if (PAL_BASE[IDX_W-1:0] != '0) begin : g_bad_base
         $error("pmx_mixer: PAL_BASE must be aligned to the palette size");
      end
   endgenerate

   // margin and playfield pattern
   logic       in_margin;
   logic       obj_blocked;
   logic [1:0] bg_pat;

   always_comb begin
      in_margin   = (pix_x < X_W'(CLIP_W));
      obj_blocked = blank_obj & in_margin;
      bg_pat      = (blank_bg & in_margin) ? 2'b00 : {bg_plane1, bg_plane0};
   end

   // per-object pixel extraction
   logic [1:0]       obj_pat [N_OBJ];
   logic [N_OBJ-1:0] obj_opaque;

   generate
      for (genvar i = 0; i < N_OBJ; i++) begin : g_obj
         pmx_obj_pixel #(.ROW_W(ROW_W)) u_pix (
            .hit  (obj_hit[i]),
            .row0 (obj_row0[i*ROW_W +: ROW_W]),
            .row1 (obj_row1[i*ROW_W +: ROW_W]),
            .col  (obj_col[i*COL_W +: COL_W]),
            .flip (obj_flip[i]),
            .pat  (obj_pat[i])
         );
         assign obj_opaque[i] = (obj_pat[i] != 2'b00) & ~obj_blocked;
      end
   endgenerate

   // ordered claim
   logic [N_OBJ-1:0] claim_first;
   logic             claim_any;

   pmx_claim #(.N(N_OBJ)) u_claim (
      .opaque (obj_opaque),
      .first  (claim_first),
      .any    (claim_any)
   );

   // one-hot selection of the claiming object's fields
   logic [1:0] win_pat;
   logic [1:0] win_pal;
   logic       win_behind;

   always_comb begin
      win_pat    = 2'b00;
      win_pal    = 2'b00;
      win_behind = 1'b0;
      for (int i = 0; i < N_OBJ; i++) begin
         win_pat    = win_pat    | ({2{claim_first[i]}} & obj_pat[i]);
         win_pal    = win_pal    | ({2{claim_first[i]}} & obj_pal[i*2 +: 2]);
         win_behind = win_behind | (claim_first[i] & obj_behind[i]);
      end
   end

   // priority between the claiming object and the playfield
   pmx_idx_t mix_idx;

   always_comb begin
      if (claim_any && (!win_behind || bg_pat == 2'b00)) begin
         mix_idx = '{is_obj: 1'b1, pal: win_pal, pat: win_pat};
      end else if (bg_pat != 2'b00) begin
         mix_idx = '{is_obj: 1'b0, pal: bg_pal, pat: bg_pat};
      end else begin
         mix_idx = '0;
      end
   end

   // output register
   pmx_idx_t idx_q;
   logic     valid_q;
   logic     margin_q, blank_bg_q, blank_obj_q, armed_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q       <= '0;
         valid_q     <= 1'b0;
         margin_q    <= 1'b0;
         blank_bg_q  <= 1'b0;
         blank_obj_q <= 1'b0;
         armed_q     <= 1'b0;
      end else begin
         valid_q <= in_valid;
         armed_q <= 1'b1;
         if (in_valid) begin
            idx_q       <= mix_idx;
            margin_q    <= in_margin;
            blank_bg_q  <= blank_bg;
            blank_obj_q <= blank_obj;
         end
      end
   end

   assign out_valid = valid_q;
   assign out_index = idx_q;
   assign out_addr  = PAL_BASE + ADDR_W'(idx_q);

   // R4
   one_claimant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(claim_first));

   // R3
   obj_opaque_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_index[IDX_W-1]) |-> (out_index[1:0] != 2'b00));

   // R2
   bg_opaque_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_index[IDX_W-1] && out_index != '0) |-> (out_index[1:0] != 2'b00));

   // R8
   obj_margin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && margin_q && blank_obj_q) |-> !out_index[IDX_W-1]);

   // R7
   bg_margin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && margin_q && blank_bg_q) |-> (out_index[IDX_W-1] || out_index == '0));

   // R10
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |-> (out_valid == $past(in_valid)));
endmodule

// File: tb/tb_pmx_mixer.sv
module tb_pmx_mixer;
   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [7:0]   pix_x = '0;
   logic         blank_bg = 1'b0, blank_obj = 1'b0;
   logic         bg_plane0 = 1'b0, bg_plane1 = 1'b0;
   logic [1:0]   bg_pal = '0;
   logic [N-1:0] obj_hit = '0, obj_flip = '0, obj_behind = '0;
   logic [N*8-1:0] obj_row0 = '0, obj_row1 = '0;
   logic [N*3-1:0] obj_col = '0;
   logic [N*2-1:0] obj_pal = '0;
   logic         out_valid;
   logic [4:0]   out_index;
   logic [13:0]  out_addr;

   int n_tests = 0;
   int n_fail  = 0;
   logic done = 1'b0;

   always #10 clk = ~clk;

   pmx_mixer #(.N_OBJ(N)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pix_x(pix_x),
      .blank_bg(blank_bg), .blank_obj(blank_obj),
      .bg_plane0(bg_plane0), .bg_plane1(bg_plane1), .bg_pal(bg_pal),
      .obj_hit(obj_hit), .obj_row0(obj_row0), .obj_row1(obj_row1),
      .obj_col(obj_col), .obj_flip(obj_flip), .obj_behind(obj_behind),
      .obj_pal(obj_pal), .out_valid(out_valid), .out_index(out_index),
      .out_addr(out_addr)
   );

   function automatic [4:0] model();
      logic [1:0] bp;
      logic       marg;
      int         who;
      logic [1:0] wp;
      marg = (pix_x < 8);
      bp   = (blank_bg && marg) ? 2'b00 : {bg_plane1, bg_plane0};
      who  = -1;
      wp   = 2'b00;
      for (int i = 0; i < N; i++) begin
         int c;
         logic [1:0] p;
         c = obj_flip[i] ? int'(obj_col[i*3 +: 3]) : 7 - int'(obj_col[i*3 +: 3]);
         p = {obj_row1[i*8 + c], obj_row0[i*8 + c]};
         if (who < 0 && obj_hit[i] && !(blank_obj && marg) && p != 2'b00) begin
            who = i;
            wp  = p;
         end
      end
      if (who >= 0 && (!obj_behind[who] || bp == 2'b00))
         return {1'b1, obj_pal[who*2 +: 2], wp};
      if (bp != 2'b00)
         return {1'b0, bg_pal, bp};
      return 5'd0;
   endfunction

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic clear_in();
      blank_bg = 0; blank_obj = 0; bg_plane0 = 0; bg_plane1 = 0; bg_pal = 0;
      obj_hit = 0; obj_flip = 0; obj_behind = 0; obj_row0 = 0; obj_row1 = 0;
      obj_col = 0; obj_pal = 0; pix_x = 8'd40;
   endtask

   // drive settled at negedge, registered at posedge, sampled next negedge
   task automatic run_px(input string req, input logic [4:0] exp);
      logic [4:0] m;
      m = model();
      in_valid = 1'b1;
      @(negedge clk);
      check(req, {27'd0, out_index}, {27'd0, exp});
      check({req, " model"}, {27'd0, out_index}, {27'd0, m});
      check("R9", {18'd0, out_addr}, {18'd0, 14'h3F00 + {9'd0, exp}});
      check("R10", {31'd0, out_valid}, 32'd1);
   endtask

   task automatic set_obj(input int i, input logic [1:0] pat, input logic [1:0] pal,
                          input logic behind);
      obj_hit[i] = 1'b1;
      obj_col[i*3 +: 3] = 3'd0;
      obj_row0[i*8 + 7] = pat[0];
      obj_row1[i*8 + 7] = pat[1];
      obj_pal[i*2 +: 2] = pal;
      obj_behind[i] = behind;
   endtask

   initial begin
      logic [31:0] s;
      clear_in();
      repeat (3) @(negedge clk);
      check("R10 reset valid", {31'd0, out_valid}, 32'd0);
      check("R10 reset index", {27'd0, out_index}, 32'd0);
      rst_n = 1'b1;

      // R1 playfield colour assembly
      clear_in(); bg_plane0 = 1; bg_plane1 = 0; bg_pal = 2'd2;
      run_px("R1", 5'd9);
      clear_in(); bg_plane0 = 0; bg_plane1 = 1; bg_pal = 2'd3;
      run_px("R1", 5'd14);
      // R2 everything see-through
      clear_in(); bg_pal = 2'd3;
      run_px("R2", 5'd0);
      // R3 object colour
      clear_in(); set_obj(0, 2'd3, 2'd1, 1'b0);
      run_px("R3", 5'd23);
      // R4 lowest index wins
      clear_in(); set_obj(2, 2'd1, 2'd3, 1'b0); set_obj(1, 2'd2, 2'd0, 1'b0);
      run_px("R4", 5'd18);
      // R5 behind object blocks later foreground object
      clear_in(); bg_plane0 = 1; bg_pal = 2'd1;
      set_obj(0, 2'd1, 2'd2, 1'b1); set_obj(1, 2'd3, 2'd3, 1'b0);
      run_px("R5 blocked", 5'd5);
      clear_in(); set_obj(0, 2'd1, 2'd2, 1'b1); set_obj(1, 2'd3, 2'd3, 1'b0);
      run_px("R5 bg clear", 5'd25);
      // R6 mirror: row bit0 set, column 0
      clear_in(); obj_hit[0] = 1; obj_row0[0] = 1'b1;
      run_px("R6 noflip", 5'd0);
      obj_flip[0] = 1'b1;
      run_px("R6 flip", 5'd17);
      // R7 playfield margin
      clear_in(); blank_bg = 1; bg_plane0 = 1; bg_plane1 = 1; pix_x = 8'd3;
      run_px("R7 inside", 5'd0);
      pix_x = 8'd8;
      run_px("R7 edge", 5'd3);
      // R8 object margin
      clear_in(); blank_obj = 1; bg_plane1 = 1; set_obj(0, 2'd1, 2'd0, 1'b0);
      pix_x = 8'd7;
      run_px("R8 inside", 5'd2);
      pix_x = 8'd8;
      run_px("R8 edge", 5'd17);
      // R11 uncovered object ignored
      clear_in(); set_obj(0, 2'd3, 2'd3, 1'b0); obj_hit[0] = 1'b0;
      set_obj(3, 2'd1, 2'd1, 1'b0);
      run_px("R11", 5'd21);
      // R10 idle cycle
      in_valid = 1'b0;
      @(negedge clk);
      check("R10 idle", {31'd0, out_valid}, 32'd0);

      // R4 R5 sweep over pseudo-random pixels
      s = 32'h1234_5678;
      for (int k = 0; k < 3000; k++) begin
         logic [4:0] e;
         s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
         pix_x = {4'd0, s[3:0]};
         blank_bg = s[4]; blank_obj = s[5];
         bg_plane0 = s[6]; bg_plane1 = s[7]; bg_pal = s[9:8];
         obj_hit = s[13:10]; obj_flip = s[17:14]; obj_behind = s[21:18];
         obj_pal = s[29:22];
         obj_col = {s[31:30], s[9:0]};
         obj_row0 = {s[15:0], s[31:16]} & {s[7:0], s[31:8]};
         obj_row1 = s ^ {s[23:0], s[31:24]};
         e = model();
         in_valid = 1'b1;
         @(negedge clk);
         check("R4 R5 sweep", {27'd0, out_index}, {27'd0, e});
      end
      in_valid = 1'b0;
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 100000 && !done; c++) @(negedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got hang expected completion");
      end
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule